// File: doc/BRIEF.md
# Spare-Opcode I/O and Carry-Control Decoder

This block gives a small accumulator machine an I/O port space and carry control without adding opcodes or memory-mapped I/O. It watches one existing opcode, the load of the accumulator into itself. That opcode ignores its operand byte and has two free instruction bits. The block uses those two bits to split the opcode into four sub-instructions. Sub-instruction 0 is the original opcode and stays a plain no-operation. Sub-instruction 1 writes the accumulator to the I/O port named by the operand byte. Sub-instruction 2 loads the carry-enable bit from accumulator bit 0. Sub-instruction 3 sets the carry flag.

Any instruction that takes the input port as its ALU source also presents its operand byte as the I/O address. Reads and writes therefore share one 256-entry port space. The whole memory space stays free for memory. The I/O data pad is split into three signals: an outgoing byte, a drive enable and an incoming byte. The drive enable is high only for the cycle of an output strobe, so that at all other times the selected peripheral can drive the bus.

An instruction is taken when `exec_en` is high at a rising edge. The results are registered and appear in the cycle after that edge.

Top module: `spare_op_decoder`

## Requirements
- R1: While `rst_n` is low at an edge, the outputs take these values after that edge: `io_wr_n`=1, `io_rd_n`=1, `io_drive`=0, `cen_wr`=0, `cset`=0, and `io_addr`, `io_dout`, `io_rd_data`, `cen_val` all 0.
- R2: An accepted instruction 0x02 (selector 00, the original opcode) raises no strobe and does not drive the bus. It leaves `io_addr`, `io_dout` and `cen_val` unchanged.
- R3: An accepted instruction 0x06 (selector 01 in bits 3:2) makes `io_wr_n` low and `io_drive` high in the next cycle, with `io_dout` equal to the accumulator and `io_addr` equal to the operand byte.
- R4: The write strobe and the drive enable last one cycle and are released together. The bus is driven only while `io_wr_n` is low.
- R5: An accepted instruction 0x0A (selector 10) pulses `cen_wr` for one cycle and sets `cen_val` to accumulator bit 0. `cen_val` holds that value until the next such instruction.
- R6: An accepted instruction 0x0E (selector 11) pulses `cset` for one cycle.
- R7: An accepted instruction whose bits 1:0 are 11 (input port as source) makes `io_rd_n` low for one cycle, with `io_addr` equal to the operand byte and the bus not driven.
- R8: At the end of the read strobe, `io_rd_data` captures `io_din` and holds it afterwards.
- R9: With `exec_en` low, no strobe is raised in the next cycle, whatever the instruction.
- R10: An instruction whose bits other than 3:2 differ from 0x02, and whose bits 1:0 are not 11, has no effect on any output.
- R11: At most one of write strobe, read strobe, `cen_wr` and `cset` is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_en | input | 1 | Execute phase: instruction accepted at this edge |
| ir | input | 8 | Instruction register |
| d_op | input | 8 | Operand byte, used as I/O port address |
| acc | input | 8 | Accumulator |
| io_din | input | 8 | Incoming byte from the I/O bus pad |
| io_dout | output | 8 | Outgoing byte toward the I/O bus pad |
| io_drive | output | 1 | High while the pad drives the bus outward |
| io_addr | output | 8 | I/O port address |
| io_wr_n | output | 1 | Write strobe, active low |
| io_rd_n | output | 1 | Read strobe, active low |
| io_rd_data | output | 8 | Byte captured at the end of a read |
| cen_wr | output | 1 | One-cycle pulse that writes the carry-enable bit |
| cen_val | output | 1 | Value for the carry-enable bit |
| cset | output | 1 | One-cycle pulse that sets the carry flag |

## Verification
The bench builds the block with its default parameters: an 8-bit instruction, the selector in bits 3:2, base opcode 0x02 and input-bus code 11. With these values all four selector codes can be reached, as can opcodes that differ from the base only outside the selector field and input reads from several instruction groups. Address and data hold across no-operations, which the bench checks by following an output with no-ops that carry different operand and accumulator values.

// File: rtl/spop_pkg.sv
// Shared types for the spare-opcode decoder.
// Assumes: one decoded kind per accepted instruction.
package spop_pkg;
    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_NOP  = 3'd1,
        K_OUT  = 3'd2,
        K_CEN  = 3'd3,
        K_CSET = 3'd4,
        K_IN   = 3'd5
    } spop_kind_e;
endpackage

// File: rtl/spop_decode.sv
// Combinational classifier: turns the instruction register into one kind.
// Assumes: the base opcode has the input-bus code absent from its bus field,
// so a spare-opcode match and an input read never coincide.
module spop_decode #(
    parameter int                IRW         = 8,
    parameter logic [IRW-1:0]    BASE_OPCODE = 8'h02,
    parameter int                SEL_LSB     = 2,
    parameter int                BUS_LSB     = 0,
    parameter int                BUS_W       = 2,
    parameter logic [BUS_W-1:0]  IN_BUS_CODE = 2'b11
) (
    input  logic                  exec_en,
    input  logic [IRW-1:0]        ir,
    output spop_pkg::spop_kind_e  kind
);
    import spop_pkg::*;

    localparam logic [IRW-1:0] SEL_MASK = IRW'(3) << SEL_LSB;
    localparam logic [IRW-1:0] BASE_FIX = BASE_OPCODE & ~SEL_MASK;

    logic       base_hit;
    logic       in_hit;
    logic [1:0] sel;

    // Match the fixed bits of the spare opcode and pick out the selector.
    always_comb begin
        base_hit = ((ir & ~SEL_MASK) == BASE_FIX);
        in_hit   = (ir[BUS_LSB +: BUS_W] == IN_BUS_CODE);
        sel      = ir[SEL_LSB +: 2];
    end

    // Map the match result onto a single kind.
    always_comb begin
        kind = K_NONE;
        if (exec_en) begin
            if (base_hit) begin
                unique case (sel)
                    2'd0: kind = K_NOP;
                    2'd1: kind = K_OUT;
                    2'd2: kind = K_CEN;
                    default: kind = K_CSET;
                endcase
            end else if (in_hit) begin
                kind = K_IN;
            end
        end
    end
endmodule

// File: rtl/spop_io_port.sv
// I/O side: registers address, outgoing byte, strobes and drive enable,
// and captures the incoming byte when a read strobe ends.
// Assumes: the peripheral answers within the read-strobe cycle.
module spop_io_port #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  spop_pkg::spop_kind_e  kind,
    input  logic [AW-1:0]         d_op,
    input  logic [DW-1:0]         acc,
    input  logic [DW-1:0]         io_din,
    output logic [DW-1:0]         io_dout,
    output logic                  io_drive,
    output logic [AW-1:0]         io_addr,
    output logic                  io_wr_n,
    output logic                  io_rd_n,
    output logic [DW-1:0]         io_rd_data
);
    import spop_pkg::*;

    // Address register: loaded by outputs and input reads, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                            io_addr <= '0;
        else if (kind == K_OUT || kind == K_IN) io_addr <= d_op;
    end

    // Outgoing data register: loaded only by an output.
    always_ff @(posedge clk) begin
        if (!rst_n)             io_dout <= '0;
        else if (kind == K_OUT) io_dout <= acc;
    end

    // Write strobe and drive enable for one cycle after an output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_wr_n  <= 1'b1;
            io_drive <= 1'b0;
        end else begin
            io_wr_n  <= (kind != K_OUT);
            io_drive <= (kind == K_OUT);
        end
    end

    // Read strobe for one cycle after an input read.
    always_ff @(posedge clk) begin
        if (!rst_n) io_rd_n <= 1'b1;
        else        io_rd_n <= (kind != K_IN);
    end

    // Capture the bus value at the edge that ends a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)        io_rd_data <= '0;
        else if (!io_rd_n) io_rd_data <= io_din;
    end
endmodule

// File: rtl/spop_carry_strobe.sv
// Carry control: one-cycle pulses for the enable write and the set,
// plus a held copy of the enable value.
// Assumes: the carry logic samples cen_val while cen_wr is high.
module spop_carry_strobe (
    input  logic                  clk,
    input  logic                  rst_n,
    input  spop_pkg::spop_kind_e  kind,
    input  logic                  acc_lsb,
    output logic                  cen_wr,
    output logic                  cen_val,
    output logic                  cset
);
    import spop_pkg::*;

    // Pulses follow the accepted sub-instruction by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_wr <= 1'b0;
            cset   <= 1'b0;
        end else begin
            cen_wr <= (kind == K_CEN);
            cset   <= (kind == K_CSET);
        end
    end

    // Enable value loaded with the write pulse and held after it.
    always_ff @(posedge clk) begin
        if (!rst_n)             cen_val <= 1'b0;
        else if (kind == K_CEN) cen_val <= acc_lsb;
    end
endmodule

// File: rtl/spare_op_decoder.sv
// Top: decodes the spare no-operation opcode into I/O output, carry-enable
// write and carry set, and turns input-port reads into addressed reads.
// Assumes: exec_en marks the single edge at which an instruction executes.
module spare_op_decoder #(
    parameter int                IRW         = 8,
    parameter int                DW          = 8,
    parameter int                AW          = 8,
    parameter logic [IRW-1:0]    BASE_OPCODE = 8'h02,
    parameter int                SEL_LSB     = 2,
    parameter int                BUS_LSB     = 0,
    parameter int                BUS_W       = 2,
    parameter logic [BUS_W-1:0]  IN_BUS_CODE = 2'b11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           exec_en,
    input  logic [IRW-1:0] ir,
    input  logic [AW-1:0]  d_op,
    input  logic [DW-1:0]  acc,
    input  logic [DW-1:0]  io_din,
    output logic [DW-1:0]  io_dout,
    output logic           io_drive,
    output logic [AW-1:0]  io_addr,
    output logic           io_wr_n,
    output logic           io_rd_n,
    output logic [DW-1:0]  io_rd_data,
    output logic           cen_wr,
    output logic           cen_val,
    output logic           cset
);
    spop_pkg::spop_kind_e kind;

    spop_decode #(
        .IRW(IRW), .BASE_OPCODE(BASE_OPCODE), .SEL_LSB(SEL_LSB),
        .BUS_LSB(BUS_LSB), .BUS_W(BUS_W), .IN_BUS_CODE(IN_BUS_CODE)
    ) u_dec (
        .exec_en (exec_en),
        .ir      (ir),
        .kind    (kind)
    );

    spop_io_port #(.DW(DW), .AW(AW)) u_io (
        .clk        (clk),
        .rst_n      (rst_n),
        .kind       (kind),
        .d_op       (d_op),
        .acc        (acc),
        .io_din     (io_din),
        .io_dout    (io_dout),
        .io_drive   (io_drive),
        .io_addr    (io_addr),
        .io_wr_n    (io_wr_n),
        .io_rd_n    (io_rd_n),
        .io_rd_data (io_rd_data)
    );

    spop_carry_strobe u_cy (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .acc_lsb (acc[0]),
        .cen_wr  (cen_wr),
        .cen_val (cen_val),
        .cset    (cset)
    );
endmodule

// File: rtl/spare_op_decoder_chk.sv
// Checker for spare_op_decoder: relates accepted instructions at the ports
// to the registered strobes one cycle later. Attached by bind below.
module spare_op_decoder_chk #(
    parameter int                IRW         = 8,
    parameter int                DW          = 8,
    parameter int                AW          = 8,
    parameter logic [IRW-1:0]    BASE_OPCODE = 8'h02,
    parameter int                SEL_LSB     = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           exec_en,
    input logic [IRW-1:0] ir,
    input logic [AW-1:0]  d_op,
    input logic [DW-1:0]  acc,
    input logic [DW-1:0]  io_dout,
    input logic           io_drive,
    input logic [AW-1:0]  io_addr,
    input logic           io_wr_n,
    input logic           io_rd_n,
    input logic           cen_wr,
    input logic           cen_val,
    input logic           cset
);
    localparam logic [IRW-1:0] SEL_MASK = IRW'(3) << SEL_LSB;
    localparam logic [IRW-1:0] C_NOP  = BASE_OPCODE & ~SEL_MASK;
    localparam logic [IRW-1:0] C_OUT  = C_NOP | (IRW'(1) << SEL_LSB);
    localparam logic [IRW-1:0] C_CEN  = C_NOP | (IRW'(2) << SEL_LSB);
    localparam logic [IRW-1:0] C_CSET = C_NOP | (IRW'(3) << SEL_LSB);

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && ir == C_NOP) |=> (io_wr_n && io_rd_n && !io_drive && !cen_wr && !cset
                                      && $stable(io_addr) && $stable(io_dout) && $stable(cen_val))); // R2
    AST_OUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && ir == C_OUT) |=> (!io_wr_n && io_drive
                                      && io_dout == $past(acc) && io_addr == $past(d_op))); // R3
    AST_DRIVE_IN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        io_drive |-> !io_wr_n); // R4
    AST_CEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && ir == C_CEN) |=> (cen_wr && cen_val == $past(acc[0]))); // R5
    AST_CSET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && ir == C_CSET) |=> cset); // R6
    AST_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && ir[1:0] == 2'b11) |=> (!io_rd_n && !io_drive && io_addr == $past(d_op))); // R7
    AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_en |=> (io_wr_n && io_rd_n && !cen_wr && !cset)); // R9
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!io_wr_n, !io_rd_n, cen_wr, cset})); // R11
endmodule

bind spare_op_decoder spare_op_decoder_chk #(
    .IRW(IRW), .DW(DW), .AW(AW), .BASE_OPCODE(BASE_OPCODE), .SEL_LSB(SEL_LSB)
) u_chk (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .ir(ir), .d_op(d_op), .acc(acc),
    .io_dout(io_dout), .io_drive(io_drive), .io_addr(io_addr), .io_wr_n(io_wr_n),
    .io_rd_n(io_rd_n), .cen_wr(cen_wr), .cen_val(cen_val), .cset(cset)
);

// File: tb/spare_op_decoder_test.sv
`timescale 1ns/1ps
module spare_op_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b0;
    logic [7:0] ir = 8'h00, d_op = 8'h00, acc = 8'h00, io_din = 8'h00;
    logic [7:0] io_dout, io_addr, io_rd_data;
    logic       io_drive, io_wr_n, io_rd_n, cen_wr, cen_val, cset;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    spare_op_decoder uut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .ir(ir), .d_op(d_op), .acc(acc),
        .io_din(io_din), .io_dout(io_dout), .io_drive(io_drive), .io_addr(io_addr),
        .io_wr_n(io_wr_n), .io_rd_n(io_rd_n), .io_rd_data(io_rd_data),
        .cen_wr(cen_wr), .cen_val(cen_val), .cset(cset)
    );

    // expected kinds: 0 none, 1 output, 2 carry-enable write, 3 carry set, 4 input read
    localparam logic [26:0] VEC [0:12] = '{
        {8'h02, 8'h55, 8'hAA, 3'd0},
        {8'h06, 8'h12, 8'h34, 3'd1},
        {8'h02, 8'hFF, 8'hFF, 3'd0},
        {8'h0A, 8'h00, 8'h01, 3'd2},
        {8'h0A, 8'h33, 8'hFE, 3'd2},
        {8'h0E, 8'h44, 8'h00, 3'd3},
        {8'h03, 8'h40, 8'h11, 3'd4},
        {8'h12, 8'h77, 8'h99, 3'd0},
        {8'h82, 8'h66, 8'h88, 3'd0},
        {8'h06, 8'hFF, 8'h00, 3'd1},
        {8'hE3, 8'h0C, 8'h22, 3'd4},
        {8'h1E, 8'h5E, 8'h5E, 3'd0},
        {8'h00, 8'hA5, 8'h5A, 3'd0}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic chk_reset_state(input string req);
        chk(req, "io_wr_n", io_wr_n, 1);
        chk(req, "io_rd_n", io_rd_n, 1);
        chk(req, "io_drive", io_drive, 0);
        chk(req, "cen_wr", cen_wr, 0);
        chk(req, "cset", cset, 0);
        chk(req, "io_addr", io_addr, 0);
        chk(req, "io_dout", io_dout, 0);
        chk(req, "io_rd_data", io_rd_data, 0);
        chk(req, "cen_val", cen_val, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] m_addr, m_dout, m_rd;
        logic       m_cval;
        repeat (3) @(negedge clk);
        chk_reset_state("R1");
        rst_n = 1'b1;
        m_addr = 8'h00; m_dout = 8'h00; m_rd = 8'h00; m_cval = 1'b0;

        // table walk
        for (int i = 0; i < 13; i++) begin
            logic [7:0] v_ir, v_d, v_a;
            logic [2:0] v_k;
            {v_ir, v_d, v_a, v_k} = VEC[i];
            @(negedge clk);
            ir = v_ir; d_op = v_d; acc = v_a; exec_en = 1'b1;
            io_din = v_d ^ 8'h5A;
            @(negedge clk);
            exec_en = 1'b0;
            if (v_k == 3'd1) begin m_addr = v_d; m_dout = v_a; end
            if (v_k == 3'd4) begin m_addr = v_d; m_rd = v_d ^ 8'h5A; end
            if (v_k == 3'd2) m_cval = v_a[0];
            // R3 write, R7 read, R5 enable, R6 set, R2/R10 no effect
            chk((v_k == 3'd1) ? "R3" : "R2/R10", "io_wr_n", io_wr_n, (v_k == 3'd1) ? 0 : 1);
            chk((v_k == 3'd1) ? "R3" : "R4", "io_drive", io_drive, (v_k == 3'd1) ? 1 : 0);
            chk((v_k == 3'd4) ? "R7" : "R10", "io_rd_n", io_rd_n, (v_k == 3'd4) ? 0 : 1);
            chk((v_k == 3'd2) ? "R5" : "R10", "cen_wr", cen_wr, (v_k == 3'd2) ? 1 : 0);
            chk((v_k == 3'd3) ? "R6" : "R10", "cset", cset, (v_k == 3'd3) ? 1 : 0);
            chk("R3/R7", "io_addr", io_addr, m_addr);
            chk("R3", "io_dout", io_dout, m_dout);
            chk("R5", "cen_val", cen_val, m_cval);
            // one cycle later: strobes released, read data captured
            @(negedge clk);
            chk("R4", "io_wr_n after", io_wr_n, 1);
            chk("R4", "io_drive after", io_drive, 0);
            chk("R7", "io_rd_n after", io_rd_n, 1);
            chk("R5/R6", "pulses after", {cen_wr, cset}, 0);
            chk("R8", "io_rd_data", io_rd_data, m_rd);
        end

        // R9: output opcode presented with exec_en low
        @(negedge clk);
        ir = 8'h06; d_op = 8'hC3; acc = 8'h3C; exec_en = 1'b0;
        @(negedge clk);
        chk("R9", "io_wr_n", io_wr_n, 1);
        chk("R9", "io_addr", io_addr, m_addr);
        chk("R9", "io_dout", io_dout, m_dout);
        ir = 8'h0E;
        @(negedge clk);
        chk("R9", "cset", cset, 0);

        // R11 + R4: back-to-back output then carry set, one strobe per cycle
        ir = 8'h06; d_op = 8'h81; acc = 8'h18; exec_en = 1'b1;
        @(negedge clk);
        ir = 8'h0E;
        chk("R3", "io_addr b2b", io_addr, 8'h81);
        chk("R3", "io_dout b2b", io_dout, 8'h18);
        @(negedge clk);
        exec_en = 1'b0;
        chk("R11", "strobes", {io_wr_n, io_rd_n, cen_wr, cset}, 4'b1101);
        chk("R4", "io_drive b2b", io_drive, 0);

        // R1: reset in the middle of a write strobe
        @(negedge clk);
        ir = 8'h06; d_op = 8'h99; acc = 8'h77; exec_en = 1'b1;
        @(negedge clk);
        exec_en = 1'b0;
        chk("R3", "io_wr_n pre-reset", io_wr_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk_reset_state("R1");
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule